// File: doc/BRIEF.md
# Corrected Error Syndrome Counter

This block keeps a 64-bit miscellaneous error record for one memory array that reports corrected errors. The first corrected error after the record is armed has its location latched as the reference syndrome. The location is given as way, unit index, array, subarray, bank and subbank. Every later corrected error is compared with that reference. Errors whose location matches add to a repeat counter. Errors at any other location add to an other counter.

Each counter is 7 bits wide. It wraps to zero when it increments past 127, and when it wraps it sets a sticky overflow flag. Either flag, when the corrected-fault interrupt enable is high, raises a registered fault-handling interrupt.

Software reads the whole record through a plain read port. A write port loads the whole record in one cycle. Through it, software can preset a counter to a threshold, clear the overflow flags, or re-arm the syndrome latch.

Top module: `ces_record`

## Requirements
- R1: Record layout:
  - bits [63:48] and [13:1] always read 0;
  - other overflow flag is bit 47; other count is [46:40];
  - repeat overflow flag is bit 39; repeat count is [38:32];
  - syndrome is [31:14], with way [31:28], unit index [27:24], array [23:20], subarray [19:18], bank [17:16] and subbank [15:14];
  - the recorded flag is bit 0.
- R2: A synchronous active-high reset clears every record bit and the interrupt output.
- R3: An error reported while the recorded flag is 0 latches its location into the syndrome field, sets the recorded flag and increments the repeat count.
- R4: An error reported while the recorded flag is 1, with a location equal to the latched syndrome, increments only the repeat count.
- R5: An error reported while the recorded flag is 1, with a location different from the latched syndrome, increments only the other count and leaves the syndrome unchanged.
- R6: A counter that increments from 127 becomes 0 and sets its own overflow flag.
- R7: An overflow flag, once set, stays 1 through further errors and wraps until a software write loads it with 0.
- R8: A software write loads every non-reserved field from the write data in one cycle, including preset count values.
- R9: When a software write and an error report occur in the same cycle, the write data is loaded and the error has no effect.
- R10: The interrupt output equals, one cycle later, the value of the interrupt enable ANDed with the OR of the two overflow flags.
- R11: After software writes the recorded flag to 0, the next error latches its own location as a new syndrome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Corrected error reported this cycle |
| err_loc | input | 18 | Location of the error, in the same packing as record bits [31:14] |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write data |
| rd_data | output | 64 | Current record contents |
| irq_en | input | 1 | Corrected-fault interrupt enable |
| irq | output | 1 | Fault-handling interrupt |

## Verification
The bench drives each counter to 127 and adds one more error. A design that saturates, or that clears the count without raising the flag, is caught here.

Same-cycle write and error collisions are also driven. A design that merges the increment into the written value shows up as an off-by-one count.

The bench re-arms the latch and reports a new location. A design that keeps the old syndrome would then count the new location's errors as other instead of repeat.

Enable and flag combinations are toggled while the interrupt latency is checked. Random traffic over a small set of locations mixes matches, mismatches and writes, and compares the whole record every cycle.

// File: rtl/ces_pkg.sv
package ces_pkg;

    localparam int REC_W    = 64;
    localparam int CNT_W    = 7;
    localparam int WAY_W    = 4;
    localparam int UNIT_W   = 4;
    localparam int ARR_W    = 4;
    localparam int SUBA_W   = 2;
    localparam int BANK_W   = 2;
    localparam int SBANK_W  = 2;
    localparam int SYN_W    = WAY_W + UNIT_W + ARR_W + SUBA_W + BANK_W + SBANK_W;
    localparam int RSVD_HI_W = 16;
    localparam int RSVD_LO_W = REC_W - RSVD_HI_W - 2 * (CNT_W + 1) - SYN_W - 1;

    typedef struct packed {
        logic [WAY_W-1:0]   way;
        logic [UNIT_W-1:0]  unit;
        logic [ARR_W-1:0]   arr;
        logic [SUBA_W-1:0]  suba;
        logic [BANK_W-1:0]  bank;
        logic [SBANK_W-1:0] sbank;
    } syn_t;

    typedef struct packed {
        logic [RSVD_HI_W-1:0] rsvd_hi;
        logic                 ovf_oth;
        logic [CNT_W-1:0]     cnt_oth;
        logic                 ovf_rep;
        logic [CNT_W-1:0]     cnt_rep;
        syn_t                 syn;
        logic [RSVD_LO_W-1:0] rsvd_lo;
        logic                 recorded;
    } record_t;

    function automatic record_t build_record(
        input logic ovf_o, input logic [CNT_W-1:0] cnt_o,
        input logic ovf_r, input logic [CNT_W-1:0] cnt_r,
        input syn_t syn, input logic rec);
        record_t r;
        r.rsvd_hi  = '0;
        r.ovf_oth  = ovf_o;
        r.cnt_oth  = cnt_o;
        r.ovf_rep  = ovf_r;
        r.cnt_rep  = cnt_r;
        r.syn      = syn;
        r.rsvd_lo  = '0;
        r.recorded = rec;
        return r;
    endfunction

endpackage

// File: rtl/ces_ctr.sv
module ces_ctr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_cnt,
    input  logic         ld_ovf,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (ld) begin
            cnt <= ld_cnt;
            ovf <= ld_ovf;
        end else if (inc) begin
            if (cnt == MAXV) begin
                cnt <= '0;
                ovf <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: increment from the top value wraps and flags
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && cnt == MAXV) |=> (cnt == '0 && ovf));

    // R7: flag only falls through a load
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ld) |=> ovf);

endmodule

// File: rtl/ces_syn.sv
module ces_syn
    import ces_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  syn_t ld_syn,
    input  logic ld_rec,
    input  logic ev,
    input  syn_t loc,
    output syn_t syn,
    output logic recorded,
    output logic inc_rep,
    output logic inc_oth
);
    logic hit;

    always_comb begin
        hit     = (loc == syn);
        inc_rep = ev && !ld && (!recorded || hit);
        inc_oth = ev && !ld && recorded && !hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syn      <= '0;
            recorded <= 1'b0;
        end else if (ld) begin
            syn      <= ld_syn;
            recorded <= ld_rec;
        end else if (ev && !recorded) begin
            syn      <= loc;
            recorded <= 1'b1;
        end
    end

    // R5: latched syndrome holds once recorded
    a_r5_syn_hold: assert property (@(posedge clk) disable iff (rst)
        (recorded && !ld) |=> (recorded && syn == $past(syn)));

    // R3: first error latches its location
    a_r3_first_latch: assert property (@(posedge clk) disable iff (rst)
        (ev && !recorded && !ld) |=> (recorded && syn == $past(loc)));

endmodule

// File: rtl/ces_record.sv
module ces_record
    import ces_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             err_valid,
    input  logic [SYN_W-1:0] err_loc,
    input  logic             wr_en,
    input  logic [REC_W-1:0] wr_data,
    output logic [REC_W-1:0] rd_data,
    input  logic             irq_en,
    output logic             irq
);
    record_t         wr_rec;
    syn_t            syn;
    logic            recorded;
    logic            inc_rep;
    logic            inc_oth;
    logic [CNT_W-1:0] cnt_rep;
    logic [CNT_W-1:0] cnt_oth;
    logic            ovf_rep;
    logic            ovf_oth;

    assign wr_rec = record_t'(wr_data);

    ces_syn u_syn (
        .clk      (clk),
        .rst      (rst),
        .ld       (wr_en),
        .ld_syn   (wr_rec.syn),
        .ld_rec   (wr_rec.recorded),
        .ev       (err_valid),
        .loc      (syn_t'(err_loc)),
        .syn      (syn),
        .recorded (recorded),
        .inc_rep  (inc_rep),
        .inc_oth  (inc_oth)
    );

    ces_ctr #(.W(CNT_W)) u_rep (
        .clk    (clk),
        .rst    (rst),
        .ld     (wr_en),
        .ld_cnt (wr_rec.cnt_rep),
        .ld_ovf (wr_rec.ovf_rep),
        .inc    (inc_rep),
        .cnt    (cnt_rep),
        .ovf    (ovf_rep)
    );

    ces_ctr #(.W(CNT_W)) u_oth (
        .clk    (clk),
        .rst    (rst),
        .ld     (wr_en),
        .ld_cnt (wr_rec.cnt_oth),
        .ld_ovf (wr_rec.ovf_oth),
        .inc    (inc_oth),
        .cnt    (cnt_oth),
        .ovf    (ovf_oth)
    );

    assign rd_data = build_record(ovf_oth, cnt_oth, ovf_rep, cnt_rep, syn, recorded);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_en && (ovf_oth || ovf_rep);
    end

    // R10: interrupt follows enable and flags one cycle later
    a_r10_irq_set: assert property (@(posedge clk) disable iff (rst)
        (irq_en && (rd_data[47] || rd_data[39])) |=> irq);
    a_r10_irq_clr: assert property (@(posedge clk) disable iff (rst)
        !(irq_en && (rd_data[47] || rd_data[39])) |=> !irq);

    // R9: a write wins over a same-cycle error
    a_r9_wr_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[47:14] == $past(wr_data[47:14]) && rd_data[0] == $past(wr_data[0])));

endmodule

// File: tb/ces_record_bench.sv
`timescale 1ns/1ps
module ces_record_bench;
    localparam logic [63:0] WMASK = 64'h0000_FFFF_FFFF_C001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_valid = 1'b0;
    logic [17:0] err_loc = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        irq_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_rec = '0;
    logic        exp_irq = 1'b0;

    always #2 clk = ~clk;

    ces_record u_ces_record (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_loc(err_loc),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_en(irq_en), .irq(irq)
    );

    function automatic logic [63:0] bump_rep(input logic [63:0] r);
        logic [63:0] n = r;
        if (r[38:32] == 7'd127) begin n[38:32] = '0; n[39] = 1'b1; end
        else n[38:32] = r[38:32] + 7'd1;
        return n;
    endfunction

    function automatic logic [63:0] bump_oth(input logic [63:0] r);
        logic [63:0] n = r;
        if (r[46:40] == 7'd127) begin n[46:40] = '0; n[47] = 1'b1; end
        else n[46:40] = r[46:40] + 7'd1;
        return n;
    endfunction

    function automatic logic [63:0] model_next(input logic [63:0] r, input logic ev,
        input logic [17:0] loc, input logic wr, input logic [63:0] wd);
        logic [63:0] n = r;
        if (wr) n = wd & WMASK;
        else if (ev) begin
            if (!r[0]) begin
                n[31:14] = loc;
                n[0] = 1'b1;
                n = bump_rep(n);
            end else if (loc == r[31:14]) n = bump_rep(r);
            else n = bump_oth(r);
        end
        return n;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ev, input logic [17:0] loc, input logic wr,
        input logic [63:0] wd, input logic ie, input string tag);
        err_valid = ev; err_loc = loc; wr_en = wr; wr_data = wd; irq_en = ie;
        @(posedge clk);
        exp_irq = ie && (exp_rec[47] || exp_rec[39]);
        exp_rec = model_next(exp_rec, ev, loc, wr, wd);
        #1;
        check(tag, rd_data, exp_rec);
        check("R10 irq", {63'd0, irq}, {63'd0, exp_irq});
        @(negedge clk);
    endtask

    function automatic logic [63:0] mk(input logic ovo, input logic [6:0] co,
        input logic ovr, input logic [6:0] cr, input logic [17:0] s, input logic rec);
        return {16'd0, ovo, co, ovr, cr, s, 13'd0, rec};
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [17:0] la, lb, lc;
        logic [17:0] locs [3];
        void'($urandom(32'd20240611));
        la = 18'h2A5C3; lb = 18'h15A3C; lc = 18'h3F001;
        locs[0] = la; locs[1] = lb; locs[2] = lc;
        @(negedge clk); @(negedge clk);
        #0;
        check("R2 reset rec", rd_data, 64'd0);
        check("R2 reset irq", {63'd0, irq}, 64'd0);
        rst = 1'b0;

        cyc(1, la, 0, 0, 1, "R3 first latch");
        cyc(1, la, 0, 0, 1, "R4 match");
        cyc(1, lb, 0, 0, 1, "R5 mismatch");
        cyc(0, lb, 0, 0, 1, "R5 idle");
        cyc(0, 0, 1, mk(0, 7'd127, 0, 7'd127, la, 1), 1, "R8 preset");
        cyc(1, la, 0, 0, 1, "R6 repeat wrap");
        cyc(0, 0, 0, 0, 1, "R10 irq rises");
        cyc(1, lc, 0, 0, 0, "R6 other wrap");
        cyc(0, 0, 0, 0, 0, "R10 disabled");
        cyc(1, la, 0, 0, 1, "R7 sticky");
        cyc(0, 0, 1, mk(0, 7'd5, 1, 7'd3, la, 1), 1, "R7 clear other");
        cyc(0, 0, 1, mk(0, 7'd5, 0, 7'd3, la, 1), 1, "R7 clear repeat");
        cyc(0, 0, 0, 0, 1, "R10 irq falls");
        cyc(1, la, 1, mk(0, 7'd9, 0, 7'd9, lb, 1), 1, "R9 collision");
        cyc(1, lb, 0, 0, 1, "R9 after collision");
        cyc(0, 0, 1, mk(0, 7'd1, 0, 7'd2, la, 0), 1, "R11 rearm");
        cyc(1, lc, 0, 0, 1, "R11 relatch");
        cyc(1, lc, 0, 0, 1, "R11 new match");
        cyc(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R1 reserved zero");
        cyc(0, 0, 0, 0, 1, "R1 hold");

        for (int i = 0; i < 600; i++) begin
            logic ev, wr, ie;
            logic [63:0] wd;
            ev = ($urandom % 3) != 0;
            wr = ($urandom % 24) == 0;
            ie = ($urandom % 4) != 0;
            wd = {$urandom, $urandom};
            if (($urandom % 2) == 0) wd[31:14] = locs[$urandom % 3];
            cyc(ev, locs[$urandom % 3], wr, wd, ie, "R4 R5 R6 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule